// File: doc/BRIEF.md
# Remote Reconfiguration Supervisor

This block decides which configuration image a device runs after each reconfiguration. It models a supervisor that starts in the factory image and keeps a boot address for an application image. It asks a separate image loader to bring in either the factory image or the application image, and it watches a running application with a programmable watchdog. Each time a reconfiguration happens, it stores a one-hot cause code in a two-entry history. Software can read that history to find why the current image is running.

Software sets the boot address, the watchdog timeout and the watchdog enable from the factory image. It then writes the reconfigure command, and the supervisor requests an application load. The application may later fail to load, stop kicking the watchdog, see a status error or an external configuration reset, or ask for reconfiguration itself. In every one of these cases the supervisor loads the factory image again. An application can never hand over directly to another application.

The loader request is a valid/ready style handshake. `load_valid` stays high, with `load_factory` and `load_addr` held stable, until the loader answers with `load_done` together with a result code. The loader may hold off `load_done` for any number of cycles. A `load_done` that arrives while no request is open is ignored.

Top module: `rcfg_supervisor`

## Requirements
- R1: After reset the block is in factory mode (`app_mode`=0) with no load request open. Boot address, timeout, watchdog enable and both history entries all read 0.
- R2: The register port uses these word offsets: 0 boot address, 1 watchdog timeout (12 bits, upper bits dropped), 2 watchdog enable (bit 0), 3 reconfigure command (write 1 to bit 0; reads 0), 4 mode (bit 0 = application), 5 latest cause, 6 older cause. Writes to offsets 0 to 2 take effect only in factory mode and are ignored otherwise. `reg_rvalid` and `reg_rdata` appear one cycle after `reg_rd`.
- R3: A reconfigure command in factory mode records cause bit 0 and opens an application load at the boot address (`load_factory`=0). `load_valid`, `load_addr` and `load_factory` stay stable until `load_done`.
- R4: For an application load, result code 0 enters application mode. Code 1 (CRC error) records cause bit 3 and opens a factory load. Codes 2 and 3 (empty region) record cause bit 2 and open a factory load. A factory load always returns to factory mode when `load_done` arrives.
- R5: A reconfigure command in application mode records cause bit 0 and opens a factory load, never an application load.
- R6: With the watchdog enabled, the counter is reloaded with timeout << WDT_LOW_W on entry to application mode. Without a kick, application mode lasts exactly (timeout << WDT_LOW_W)+1 cycles. It then records cause bit 1 and opens a factory load. A kick seen in application cycle j (counted from 0) extends the stay to j+(timeout << WDT_LOW_W)+2 cycles. With the watchdog disabled, application mode never times out.
- R7: `nstatus_err` in application mode records cause bit 2 and opens a factory load. In factory mode it is ignored.
- R8: `ext_cfg_rst` in factory or application mode records cause bit 4 and opens a factory load. It is ignored while a load is open.
- R9: Causes are one-hot in 5 bits. Recording a cause moves the latest entry into the older entry and stores the new cause as the latest.
- R10: When several events arrive in the same application cycle, priority from highest to lowest is external reset, status error, watchdog expiry, reconfigure command.
- R11: `load_done` while `load_valid` is low changes neither mode nor history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| ext_cfg_rst | input | 1 | External configuration reset event |
| nstatus_err | input | 1 | Status error reported by an external device |
| app_kick | input | 1 | Watchdog kick from the application |
| load_valid | output | 1 | Image load request open |
| load_factory | output | 1 | Request targets the factory image |
| load_addr | output | ADDR_W | Start address of the requested image |
| load_done | input | 1 | Loader response, accepted while load_valid is high |
| load_status | input | 2 | Load result: 0 ok, 1 CRC error, 2 or 3 empty region |
| app_mode | output | 1 | Application image running |

## Verification
The hardest case to reach is a collision in a single application cycle: a kick or a reconfigure command arriving in the same cycle as watchdog expiry, a status error or an external reset. The bench sets the timeout to zero so that expiry falls in the first application cycle. It then drives the competing events from the negative edge of that cycle. It also sweeps the kick position across every cycle of a short timeout window and compares the stay length against the arithmetic formula.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  typedef enum logic [1:0] {
    ST_FACTORY   = 2'd0,
    ST_LOAD_APP  = 2'd1,
    ST_APP       = 2'd2,
    ST_LOAD_FACT = 2'd3
  } sup_state_e;

  localparam int CW = 5;
  localparam int CZ_LOGIC  = 0;
  localparam int CZ_WDOG   = 1;
  localparam int CZ_NSTAT  = 2;
  localparam int CZ_CRC    = 3;
  localparam int CZ_EXTRST = 4;

  localparam logic [1:0] LD_OK  = 2'd0;
  localparam logic [1:0] LD_CRC = 2'd1;

  localparam int OFF_BOOT   = 0;
  localparam int OFF_TMO    = 1;
  localparam int OFF_WDEN   = 2;
  localparam int OFF_RECONF = 3;
  localparam int OFF_MODE   = 4;
  localparam int OFF_HIST0  = 5;

  function automatic logic [CW-1:0] cause_vec(input int b);
    return CW'(1) << b;
  endfunction
endpackage

// File: rtl/rcfg_regs.sv
module rcfg_regs
  import rcfg_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int TMO_W      = 12,
  parameter int DATA_W     = 32,
  parameter int RADDR_W    = 3,
  parameter int HIST_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [RADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     factory_mode,
  input  logic                     app_mode,
  input  logic [HIST_DEPTH*CW-1:0] hist_flat,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rvalid,
  output logic [ADDR_W-1:0]        boot_addr,
  output logic [TMO_W-1:0]         tmo,
  output logic                     wd_en,
  output logic                     reconf_cmd
);
  logic [DATA_W-1:0] rd_mux;
  logic              cfg_wr;

  assign cfg_wr     = wr && factory_mode;
  assign reconf_cmd = wr && (addr == RADDR_W'(OFF_RECONF)) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_addr <= '0;
      tmo       <= '0;
      wd_en     <= 1'b0;
    end else if (cfg_wr) begin
      if (addr == RADDR_W'(OFF_BOOT)) boot_addr <= wdata[ADDR_W-1:0];
      if (addr == RADDR_W'(OFF_TMO))  tmo       <= wdata[TMO_W-1:0];
      if (addr == RADDR_W'(OFF_WDEN)) wd_en     <= wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == RADDR_W'(OFF_BOOT)) rd_mux[ADDR_W-1:0] = boot_addr;
    if (addr == RADDR_W'(OFF_TMO))  rd_mux[TMO_W-1:0]  = tmo;
    if (addr == RADDR_W'(OFF_WDEN)) rd_mux[0]          = wd_en;
    if (addr == RADDR_W'(OFF_MODE)) rd_mux[0]          = app_mode;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (addr == RADDR_W'(OFF_HIST0 + i)) rd_mux[CW-1:0] = hist_flat[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rcfg_wdog.sv
module rcfg_wdog #(
  parameter int TMO_W = 12,
  parameter int LOW_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [TMO_W-1:0] tmo,
  input  logic             load,
  input  logic             kick,
  output logic             expire
);
  localparam int CNT_W = TMO_W + LOW_W;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;

  assign reload = {tmo, {LOW_W{1'b0}}};
  assign expire = run && en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= reload;
    else if (run && en) begin
      if (cnt == '0)         cnt <= cnt;
      else if (kick)         cnt <= reload;
      else                   cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rcfg_hist.sv
module rcfg_hist
  import rcfg_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [CW-1:0]       cause,
  output logic [DEPTH*CW-1:0] hist_flat
);
  logic [CW-1:0] h_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) h_q[i] <= '0;
    end else if (push) begin
      h_q[0] <= cause;
      for (int i = 1; i < DEPTH; i++) h_q[i] <= h_q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign hist_flat[g*CW +: CW] = h_q[g];
  end
endmodule

// File: rtl/rcfg_supervisor.sv
module rcfg_supervisor
  import rcfg_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int WDT_LOW_W    = 17,
  parameter int FACTORY_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic              ext_cfg_rst,
  input  logic              nstatus_err,
  input  logic              app_kick,
  output logic              load_valid,
  output logic              load_factory,
  output logic [ADDR_W-1:0] load_addr,
  input  logic              load_done,
  input  logic [1:0]        load_status,
  output logic              app_mode
);
  localparam int TMO_W      = 12;
  localparam int HIST_DEPTH = 2;

  sup_state_e               state, nstate;
  logic                     push;
  logic [CW-1:0]            cause;
  logic                     wd_load, wd_expire;
  logic [ADDR_W-1:0]        boot_addr;
  logic [TMO_W-1:0]         tmo;
  logic                     wd_en, reconf_cmd;
  logic [HIST_DEPTH*CW-1:0] hist_flat;

  assign app_mode     = (state == ST_APP);
  assign load_valid   = (state == ST_LOAD_APP) || (state == ST_LOAD_FACT);
  assign load_factory = (state == ST_LOAD_FACT);
  assign load_addr    = load_factory ? ADDR_W'(FACTORY_ADDR) : boot_addr;

  rcfg_regs #(
    .ADDR_W(ADDR_W), .TMO_W(TMO_W), .DATA_W(32), .RADDR_W(3), .HIST_DEPTH(HIST_DEPTH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .factory_mode(state == ST_FACTORY), .app_mode(app_mode),
    .hist_flat(hist_flat), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .boot_addr(boot_addr), .tmo(tmo), .wd_en(wd_en), .reconf_cmd(reconf_cmd)
  );

  rcfg_wdog #(.TMO_W(TMO_W), .LOW_W(WDT_LOW_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(app_mode), .en(wd_en), .tmo(tmo),
    .load(wd_load), .kick(app_kick), .expire(wd_expire)
  );

  rcfg_hist #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(push), .cause(cause), .hist_flat(hist_flat)
  );

  always_comb begin
    nstate  = state;
    push    = 1'b0;
    cause   = '0;
    wd_load = 1'b0;
    unique case (state)
      ST_FACTORY: begin
        if (ext_cfg_rst) begin
          push = 1'b1; cause = cause_vec(CZ_EXTRST); nstate = ST_LOAD_FACT;
        end else if (reconf_cmd) begin
          push = 1'b1; cause = cause_vec(CZ_LOGIC); nstate = ST_LOAD_APP;
        end
      end
      ST_LOAD_APP: begin
        if (load_done) begin
          if (load_status == LD_OK) begin
            nstate = ST_APP; wd_load = 1'b1;
          end else if (load_status == LD_CRC) begin
            push = 1'b1; cause = cause_vec(CZ_CRC); nstate = ST_LOAD_FACT;
          end else begin
            push = 1'b1; cause = cause_vec(CZ_NSTAT); nstate = ST_LOAD_FACT;
          end
        end
      end
      ST_APP: begin
        if (ext_cfg_rst) begin
          push = 1'b1; cause = cause_vec(CZ_EXTRST);
        end else if (nstatus_err) begin
          push = 1'b1; cause = cause_vec(CZ_NSTAT);
        end else if (wd_expire) begin
          push = 1'b1; cause = cause_vec(CZ_WDOG);
        end else if (reconf_cmd) begin
          push = 1'b1; cause = cause_vec(CZ_LOGIC);
        end
        if (push) nstate = ST_LOAD_FACT;
      end
      ST_LOAD_FACT: begin
        if (load_done) nstate = ST_FACTORY;
      end
      default: nstate = ST_FACTORY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FACTORY;
    else        state <= nstate;
  end
endmodule

// File: rtl/rcfg_supervisor_chk.sv
module rcfg_supervisor_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_rvalid,
  input logic              ext_cfg_rst,
  input logic              nstatus_err,
  input logic              load_valid,
  input logic              load_factory,
  input logic [ADDR_W-1:0] load_addr,
  input logic              load_done,
  input logic [1:0]        load_status,
  input logic              app_mode,
  input logic [9:0]        hist_flat
);
  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && !load_done |=> load_valid && $stable(load_addr) && $stable(load_factory)); // R3
  AST_APP_VIA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(app_mode) |-> $past(load_valid && load_done && !load_factory && load_status == 2'd0)); // R4
  AST_APP_EXIT_FACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(app_mode) |-> load_valid && load_factory); // R5
  AST_NSTAT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode && nstatus_err && !ext_cfg_rst |=> !app_mode && hist_flat[2]); // R7
  AST_EXT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode && ext_cfg_rst |=> load_factory && hist_flat[4]); // R8
  AST_HIST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hist_flat[4:0]) && $onehot0(hist_flat[9:5])); // R9
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hist_flat[4:0]) |-> hist_flat[9:5] == $past(hist_flat[4:0])); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid); // R2
endmodule

bind rcfg_supervisor rcfg_supervisor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .ext_cfg_rst(ext_cfg_rst), .nstatus_err(nstatus_err), .load_valid(load_valid),
  .load_factory(load_factory), .load_addr(load_addr), .load_done(load_done),
  .load_status(load_status), .app_mode(app_mode), .hist_flat(hist_flat)
);

// File: tb/rcfg_supervisor_tb.sv
module rcfg_supervisor_tb;
  localparam int ADDR_W = 24;
  localparam int LOW_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic ext_cfg_rst = 1'b0, nstatus_err = 1'b0, app_kick = 1'b0;
  logic load_valid, load_factory, app_mode;
  logic [ADDR_W-1:0] load_addr;
  logic load_done = 1'b0;
  logic [1:0] load_status = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [4:0] eh0 = '0, eh1 = '0;

  always #4 clk = ~clk;

  rcfg_supervisor #(.ADDR_W(ADDR_W), .WDT_LOW_W(LOW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ext_cfg_rst(ext_cfg_rst), .nstatus_err(nstatus_err), .app_kick(app_kick),
    .load_valid(load_valid), .load_factory(load_factory), .load_addr(load_addr),
    .load_done(load_done), .load_status(load_status), .app_mode(app_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int b);
    eh1 = eh0;
    eh0 = 5'(1) << b;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R2 rvalid", 32'(reg_rvalid), 32'd1);
    d = reg_rdata;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    chk(req, d, exp);
  endtask

  task automatic hist_chk(input string req);
    read_chk({req, " latest"}, 3'd5, 32'(eh0));
    read_chk({req, " older"}, 3'd6, 32'(eh1));
  endtask

  task automatic serve_load(input bit fact, input logic [ADDR_W-1:0] a,
                            input logic [1:0] st, input int dly, input string req);
    int w = 0;
    while (!load_valid && w < 50) begin @(negedge clk); w++; end
    chk({req, " load_valid"}, 32'(load_valid), 32'd1);
    chk({req, " load_factory"}, 32'(load_factory), 32'(fact));
    chk({req, " load_addr"}, 32'(load_addr), fact ? 32'd0 : 32'(a));
    repeat (dly) @(negedge clk);
    chk({req, " R3 held"}, {load_valid, load_factory, load_addr[ADDR_W-1:2]},
        {1'b1, fact, fact ? 22'd0 : a[ADDR_W-1:2]});
    load_done = 1'b1; load_status = st;
    @(negedge clk);
    load_done = 1'b0; load_status = '0;
  endtask

  task automatic enter_app(input logic [ADDR_W-1:0] a);
    reg_write(3'd3, 32'd1);
    push(0);
    serve_load(1'b0, a, 2'd0, 2, "R3 app load");
    chk("R4 app_mode", 32'(app_mode), 32'd1);
  endtask

  task automatic back_to_factory(input string req);
    serve_load(1'b1, '0, 2'd0, 1, req);
    chk({req, " factory mode"}, 32'(app_mode), 32'd0);
  endtask

  task automatic wd_run(input int kick_at, output int n);
    n = 0;
    while (app_mode && n < 500) begin
      n++;
      app_kick = (kick_at >= 0) && (n == kick_at + 1);
      @(negedge clk);
    end
    app_kick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 app_mode", 32'(app_mode), 32'd0);
    chk("R1 load_valid", 32'(load_valid), 32'd0);
    for (int a = 0; a < 7; a++) if (a != 3) read_chk("R1 reg", 3'(a), 32'd0);

    // R2 register read-back and truncation
    reg_write(3'd0, 32'h00400000); read_chk("R2 boot", 3'd0, 32'h00400000);
    reg_write(3'd0, 32'hFFABCDEF); read_chk("R2 boot trunc", 3'd0, 32'h00ABCDEF);
    reg_write(3'd1, 32'h000FFFFF); read_chk("R2 tmo trunc", 3'd1, 32'h00000FFF);
    reg_write(3'd1, 32'd0);
    reg_write(3'd2, 32'd1); read_chk("R2 wden", 3'd2, 32'd1);
    reg_write(3'd2, 32'd0);
    reg_write(3'd0, 32'h00400000);
    read_chk("R2 reconf reads 0", 3'd3, 32'd0);

    // R11 stray load_done
    load_done = 1'b1; @(negedge clk); load_done = 1'b0;
    chk("R11 mode", 32'(app_mode), 32'd0);
    chk("R11 no load", 32'(load_valid), 32'd0);
    hist_chk("R11");

    // R3/R4 normal entry, R2 locked writes, R6 disabled watchdog, R5 exit
    enter_app(24'h400000);
    read_chk("R2 mode reg", 3'd4, 32'd1);
    hist_chk("R3 R9");
    reg_write(3'd0, 32'h00123456);
    reg_write(3'd2, 32'd1);
    repeat (60) @(negedge clk);
    chk("R6 disabled stays", 32'(app_mode), 32'd1);
    reg_write(3'd3, 32'd1); push(0);
    chk("R5 left app", 32'(app_mode), 32'd0);
    back_to_factory("R5");
    read_chk("R2 boot locked", 3'd0, 32'h00400000);
    read_chk("R2 wden locked", 3'd2, 32'd0);
    hist_chk("R5 R9");

    // R4 load failures, codes 1..3
    for (int s = 1; s < 4; s++) begin
      reg_write(3'd3, 32'd1); push(0);
      serve_load(1'b0, 24'h400000, 2'(s), s, "R4 fail load");
      push(s == 1 ? 3 : 2);
      chk("R4 not app", 32'(app_mode), 32'd0);
      back_to_factory("R4");
      hist_chk("R4");
    end

    // R7 status error, in factory ignored then in app
    nstatus_err = 1'b1; @(negedge clk); nstatus_err = 1'b0;
    chk("R7 factory ignore", 32'(load_valid), 32'd0);
    hist_chk("R7 ignore");
    enter_app(24'h400000);
    nstatus_err = 1'b1; @(negedge clk); nstatus_err = 1'b0; push(2);
    back_to_factory("R7");
    hist_chk("R7");

    // R8 external reset in app, in factory, and during load
    enter_app(24'h400000);
    ext_cfg_rst = 1'b1; @(negedge clk); ext_cfg_rst = 1'b0; push(4);
    back_to_factory("R8 app");
    hist_chk("R8 app");
    ext_cfg_rst = 1'b1; @(negedge clk); ext_cfg_rst = 1'b0; push(4);
    chk("R8 factory reload", 32'(load_factory), 32'd1);
    ext_cfg_rst = 1'b1; @(negedge clk); ext_cfg_rst = 1'b0;
    back_to_factory("R8 factory");
    hist_chk("R8 during load ignored");

    // R6 watchdog sweep without kick
    reg_write(3'd2, 32'd1);
    for (int t = 0; t < 4; t++) begin
      reg_write(3'd1, 32'(t));
      enter_app(24'h400000);
      wd_run(-1, n);
      chk($sformatf("R6 stay t=%0d", t), 32'(n), 32'((t << LOW_W) + 1));
      push(1);
      back_to_factory("R6");
      hist_chk("R6");
    end

    // R6 kick position sweep
    reg_write(3'd1, 32'd2);
    for (int j = 0; j < (2 << LOW_W); j++) begin
      enter_app(24'h400000);
      wd_run(j, n);
      chk($sformatf("R6 kick j=%0d", j), 32'(n), 32'(j + (2 << LOW_W) + 2));
      push(1);
      back_to_factory("R6 kick");
    end
    hist_chk("R6 kick");

    // R10 priorities
    reg_write(3'd1, 32'd0);
    enter_app(24'h400000);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd1; ext_cfg_rst = 1'b1; nstatus_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ext_cfg_rst = 1'b0; nstatus_err = 1'b0; push(4);
    back_to_factory("R10 ext");
    hist_chk("R10 ext first");
    enter_app(24'h400000);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd1; nstatus_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; nstatus_err = 1'b0; push(2);
    back_to_factory("R10 nstat");
    hist_chk("R10 nstat over wdog");
    enter_app(24'h400000);
    reg_write(3'd3, 32'd1); push(1);
    back_to_factory("R10 wdog");
    hist_chk("R10 wdog over reconf");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule